// File: doc/BRIEF.md
# Write-Masked Control Register Bank with Indirect PHY Configuration Port

This block is a small system-control register slave on a simple register bus. Each bus write carries its own per-bit write enable: the upper 16 bits of the written word choose which of the lower 16 bits are actually stored. Because of this, software can change one field without reading the register first. It can also change it without disturbing fields that other agents own.

The bank has three mapped registers:
- A lane control register, whose bits drive one idle output per PCIe lane.
- A configuration port register, which packs a strobe, a 6-bit address and a 4-bit data value for a small 4-bit-wide configuration space inside a PHY. A rising edge on the strobe bit sends exactly one write pulse to the PHY. The address and data fields drive the PHY continuously, so the same register also selects what the PHY returns on reads.
- A read-only status register, which returns the PHY's read data one clock after sampling it.

Firmware typically uses the port in these steps:
1. Brings lanes out of idle.
2. Polls the PLL-lock bit at configuration address 0x10 through the status register.
3. Writes the rate-select bit (bit 3) at address 0x10 and the reference-output enable (bit 3) at address 0x12.
4. Polls address 0x12 until the output-gated bit (bit 2) clears.

Top module: `pcfg_regbank`

## Requirements
- R1: While reset is asserted and after it, the lane control register (byte offset 0x00) reads 0x0000_0078, all four lane_idle outputs are 1, the configuration port register (offset 0x04) reads 0, and cfg_wr is 0.
- R2: A bus write to offset 0x00 or 0x04 changes stored bit n (0..15) only when bit n+16 of the written word is 1; every other stored bit keeps its value. The new value is readable in the cycle after the write.
- R3: lane_idle[i] equals bit i+3 of the lane control register (1 = lane idle), for lanes 0 to 3.
- R4: cfg_addr equals bits 6:1 and cfg_wdata equals bits 10:7 of the configuration port register, from the cycle after the write that set them.
- R5: When bit 0 of the configuration port register (the strobe) goes from 0 to 1, cfg_wr is high for exactly one cycle, namely the cycle after that write. Holding the strobe high, or rewriting it as 1, gives no further pulse.
- R6: A read of offset 0x08 returns in bits 11:8 the value cfg_rdata had one clock earlier; all other bits are 0. With the PHY addressed at 0x10, bit 9 is the PLL-locked indication.
- R7: Bits with no function read as 0: all bits of offset 0x00 except 6:3, and bits 31:11 of offset 0x04.
- R8: Reads of any offset other than 0x00, 0x04 and 0x08 return 0. Writes to those offsets, and writes to the read-only offset 0x08, change no stored state and no output.
- R9: A single write that sets the strobe and changes the address and data fields in the same word produces its pulse with the new address and data already on cfg_addr and cfg_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write word: bits 15:0 data, bits 31:16 per-bit write enables |
| bus_we | input | 1 | Write enable, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cfg_addr | output | 6 | PHY configuration address |
| cfg_wdata | output | 4 | PHY configuration write data |
| cfg_wr | output | 1 | One-cycle PHY configuration write pulse |
| cfg_rdata | input | 4 | PHY configuration read data for cfg_addr |
| lane_idle | output | 4 | Per-lane idle request, 1 = idle |

## Verification
The hardest situation to reach from the ports is a strobe write that must not pulse. Two cases matter. In the first, the strobe is already high and is written high again, or its enable bit is off while its data bit is 1. In the second, the strobe and the new address land in the same masked word. The stimulus covers both cases with directed word sequences. It then runs a long sweep of random words with random enable halves across the mapped and unmapped offsets. A behavioural model checks every cycle: masked merges, the stored strobe history, and a bench-side PHY space that tracks the PHY contents through every pulse.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LANE = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LANE,
    SEL_CFG,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_LANE: s = SEL_LANE;
      OFF_CFG:  s = SEL_CFG;
      OFF_STAT: s = SEL_STAT;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pcfg_wmreg.sv
module pcfg_wmreg #(
  parameter int           W   = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic [W-1:0] m,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         en;

  assign en = we & (|m);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign q_nxt[i] = m[i] ? d[i] : q_r[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST;
    end else if (en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/pcfg_rise_pulse.sv
module pcfg_rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);

  logic level_q;
  logic level_nxt;

  assign level_nxt = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_nxt;
    end
  end

  assign pulse = level & ~level_q;

endmodule

// File: rtl/pcfg_sample_reg.sv
module pcfg_sample_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  assign q_nxt = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/pcfg_regbank.sv
module pcfg_regbank
  import pcfg_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int IDLE_LSB  = 3,
  parameter int CFG_AW    = 6,
  parameter int CFG_DW    = 4,
  parameter int STAT_LSB  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_we,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [CFG_AW-1:0]    cfg_addr,
  output logic [CFG_DW-1:0]    cfg_wdata,
  output logic                 cfg_wr,
  input  logic [CFG_DW-1:0]    cfg_rdata,
  output logic [NUM_LANES-1:0] lane_idle
);

  localparam int CFG_STB_BIT  = 0;
  localparam int CFG_ADDR_LSB = CFG_STB_BIT + 1;
  localparam int CFG_DATA_LSB = CFG_ADDR_LSB + CFG_AW;
  localparam int CFG_W        = CFG_DATA_LSB + CFG_DW;
  localparam logic [NUM_LANES-1:0] LANE_RST = '1;

  reg_sel_e              sel;
  logic                  lane_we;
  logic                  cfg_we;
  logic [NUM_LANES-1:0]  lane_q;
  logic [CFG_W-1:0]      cfg_q;
  logic [CFG_DW-1:0]     stat_q;
  logic [BUS_W-1:0]      rd_nxt;
  logic [BUS_W-1:0]      unused_wdata;

  assign sel     = decode_addr(bus_addr);
  assign lane_we = bus_we && (sel == SEL_LANE);
  assign cfg_we  = bus_we && (sel == SEL_CFG);

  assign unused_wdata = bus_wdata;

  pcfg_wmreg #(
    .W   (NUM_LANES),
    .RST (LANE_RST)
  ) u_lane_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lane_we),
    .d     (bus_wdata[IDLE_LSB +: NUM_LANES]),
    .m     (bus_wdata[HALF_W + IDLE_LSB +: NUM_LANES]),
    .q     (lane_q)
  );

  pcfg_wmreg #(
    .W   (CFG_W),
    .RST ('0)
  ) u_cfg_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .d     (bus_wdata[CFG_W-1:0]),
    .m     (bus_wdata[HALF_W +: CFG_W]),
    .q     (cfg_q)
  );

  pcfg_rise_pulse u_stb_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (cfg_q[CFG_STB_BIT]),
    .pulse (cfg_wr)
  );

  pcfg_sample_reg #(
    .W (CFG_DW)
  ) u_stat_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cfg_rdata),
    .q     (stat_q)
  );

  assign cfg_addr  = cfg_q[CFG_ADDR_LSB +: CFG_AW];
  assign cfg_wdata = cfg_q[CFG_DATA_LSB +: CFG_DW];
  assign lane_idle = lane_q;

  always_comb begin
    rd_nxt = '0;
    case (sel)
      SEL_LANE: rd_nxt[IDLE_LSB +: NUM_LANES] = lane_q;
      SEL_CFG:  rd_nxt[CFG_W-1:0]             = cfg_q;
      SEL_STAT: rd_nxt[STAT_LSB +: CFG_DW]    = stat_q;
      default:  rd_nxt = '0;
    endcase
  end

  assign bus_rdata = rd_nxt;

endmodule

// File: rtl/pcfg_regbank_chk.sv
module pcfg_regbank_chk
  import pcfg_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CFG_AW    = 6,
  parameter int CFG_DW    = 4,
  parameter int STAT_LSB  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 stb_data,
  input logic                 stb_mask,
  input logic                 bus_we,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic [CFG_AW-1:0]    cfg_addr,
  input logic [CFG_DW-1:0]    cfg_wdata,
  input logic                 cfg_wr,
  input logic [CFG_DW-1:0]    cfg_rdata,
  input logic [NUM_LANES-1:0] lane_idle
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_wr); // R5

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> $past(bus_we && bus_addr == OFF_CFG && stb_mask && stb_data)); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFF_CFG) |=> ($stable(cfg_addr) && $stable(cfg_wdata))); // R4

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFF_LANE) |=> $stable(lane_idle)); // R8

  AST_STATUS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && bus_addr == OFF_STAT) |-> bus_rdata[STAT_LSB +: CFG_DW] == $past(cfg_rdata)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFF_LANE && bus_addr != OFF_CFG && bus_addr != OFF_STAT) |-> bus_rdata == '0); // R8

endmodule

bind pcfg_regbank pcfg_regbank_chk #(
  .NUM_LANES (NUM_LANES),
  .CFG_AW    (CFG_AW),
  .CFG_DW    (CFG_DW),
  .STAT_LSB  (STAT_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .stb_data  (bus_wdata[0]),
  .stb_mask  (bus_wdata[16]),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_wr    (cfg_wr),
  .cfg_rdata (cfg_rdata),
  .lane_idle (lane_idle)
);

// File: tb/pcfg_regbank_tb.sv
module pcfg_regbank_tb;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_wdata;
  logic        cfg_wr;
  logic [3:0]  cfg_rdata;
  logic [3:0]  lane_idle;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pcfg_regbank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .lane_idle (lane_idle)
  );

  // PHY configuration space model
  logic [3:0] phy_mem [64];
  initial begin
    for (int i = 0; i < 64; i++) phy_mem[i] = 4'(i) ^ 4'hA;
    phy_mem[6'h10] = 4'b0010;
    phy_mem[6'h12] = 4'b0100;
  end
  assign cfg_rdata = phy_mem[cfg_addr];
  always @(posedge clk) begin
    if (cfg_wr) phy_mem[cfg_addr] <= (cfg_addr == 6'h10) ? (cfg_wdata | 4'h2) : cfg_wdata;
  end

  // behavioural reference
  logic [31:0] m_lane, m_cfg;
  logic        m_prev;
  logic [3:0]  m_status;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] w);
    logic [31:0] r = old;
    for (int i = 0; i < 16; i++) if (w[i+16]) r[i] = w[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lane <= 32'h78; m_cfg <= 32'h0; m_prev <= 1'b0; m_status <= 4'h0;
    end else begin
      if (bus_we && bus_addr == 8'h00) m_lane <= merge(m_lane, bus_wdata) & 32'h78;
      if (bus_we && bus_addr == 8'h04) m_cfg  <= merge(m_cfg, bus_wdata) & 32'h7FF;
      m_prev   <= m_cfg[0];
      m_status <= phy_mem[m_cfg[6:1]];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00:   return m_lane;
      8'h04:   return m_cfg;
      8'h08:   return {20'h0, m_status, 8'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_en && rst_n) begin
      check("R3 lane_idle", 32'(lane_idle), 32'(m_lane[6:3]));
      check("R4 cfg_addr", 32'(cfg_addr), 32'(m_cfg[6:1]));
      check("R4 cfg_wdata", 32'(cfg_wdata), 32'(m_cfg[10:7]));
      check("R5 cfg_wr", 32'(cfg_wr), 32'(m_cfg[0] & ~m_prev));
      case (bus_addr)
        8'h00, 8'h04: check("R2 readback", bus_rdata, exp_rd(bus_addr));
        8'h08:        check("R6 status", bus_rdata, exp_rd(bus_addr));
        default:      check("R8 unmapped", bus_rdata, exp_rd(bus_addr));
      endcase
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 idle in reset", 32'(lane_idle), 32'hF);
    check("R1 no pulse in reset", 32'(cfg_wr), 32'h0);
    check("R1 lane reg in reset", bus_rdata, 32'h78);
    @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1'b1;
    rd(8'h00, 32'h78, "R1 lane reg");
    rd(8'h04, 32'h0, "R1 cfg reg");

    // masked lane writes
    wr(8'h00, 32'h0008_0000);
    #1 check("R3 lane0 out of idle", 32'(lane_idle), 32'hE);
    wr(8'h00, 32'h0000_0000);
    #1 check("R2 zero enables no change", 32'(lane_idle), 32'hE);
    wr(8'h00, 32'h0040_FFFF);
    #1 check("R2 only lane3 enabled", 32'(lane_idle), 32'hE);
    wr(8'h00, 32'h0078_0000);
    #1 check("R3 all lanes active", 32'(lane_idle), 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h78, "R7 lane unused bits zero");
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, 32'h7FE, "R7 cfg unused bits zero");

    // indirect write: address 0x12, data 8, then strobe
    wr(8'h04, 32'h07FE_0424);
    #1 check("R4 address field", 32'(cfg_addr), 32'h12);
    check("R5 no pulse without strobe", 32'(cfg_wr), 32'h0);
    wr(8'h04, 32'h0001_0001);
    #1 check("R5 pulse on rise", 32'(cfg_wr), 32'h1);
    @(negedge clk);
    #1 check("R5 pulse is one cycle", 32'(cfg_wr), 32'h0);
    wr(8'h04, 32'h0001_0001);
    #1 check("R5 rewrite high no pulse", 32'(cfg_wr), 32'h0);
    wr(8'h04, 32'h0000_0000);
    wr(8'h04, 32'h0001_0000);
    wr(8'h04, 32'h0000_0001);
    #1 check("R2 strobe enable off no pulse", 32'(cfg_wr), 32'h0);

    // strobe together with new address and data
    wr(8'h04, 32'h07FF_0421);
    #1 check("R9 pulse", 32'(cfg_wr), 32'h1);
    check("R9 new address with pulse", 32'(cfg_addr), 32'h10);
    check("R9 new data with pulse", 32'(cfg_wdata), 32'h8);

    // status readback
    wr(8'h04, 32'h07FF_0020);
    rd(8'h08, 32'h0000_0A00, "R6 lock bit 9 at 0x10");
    wr(8'h04, 32'h07FF_0024);
    rd(8'h08, 32'h0000_0800, "R6 output ungated at 0x12");

    // unmapped and read-only
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0078, "R8 lane reg untouched");
    rd(8'h04, 32'h0000_0024, "R8 cfg reg untouched");
    rd(8'h0C, 32'h0, "R8 unmapped read zero");

    // random sweep
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      case ($urandom % 5)
        0: bus_addr = 8'h00;
        1: bus_addr = 8'h04;
        2: bus_addr = 8'h08;
        3: bus_addr = 8'h0C;
        default: bus_addr = 8'h40;
      endcase
      bus_wdata = $urandom;
      bus_we    = ($urandom % 2) == 1;
    end
    @(negedge clk);
    bus_we = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule